// File: doc/BRIEF.md
# Paged Address Translator with Protection

The block turns a 16-bit virtual address into a physical address of up to 22 bits for one memory reference. The top three virtual bits pick one of eight pages. The block sends that page number and a space select (instruction or data) to an external register file. The register file returns the page base, an access-control code, a length field and a growth-direction bit. The physical address is the base shifted left by six plus the low thirteen virtual bits. With the wide-address enable off, the result is cut to 18 bits.

In the same cycle the block runs three checks in a fixed order: access control, then non-existent memory, then page length. Only the first check that fails is reported. The result says whether the reference aborts (vector 4) or traps (vector 250 octal). It also gives the fault kind for status capture, and a written-page attention flag with the mode, space and page that caused it. A request is taken on `req_valid && req_ready`. One cycle later the result appears on `rsp_*` under `rsp_valid`. If `rsp_ready` is low, the result is held and `req_ready` drops, so no new request is taken until the held result is consumed. A request offered while `req_ready` is low is not accepted and produces no response.

Top module: `pxl_top`

## Requirements
- R1: When translating, the physical address is `rf_base * 64 + req_vaddr[12:0]`, and `rf_page` equals `req_vaddr[15:13]`.
- R2: With `ext22_en` low the translated address is masked to its low 18 bits; with it high all 22 bits are kept.
- R3: Translation applies when `xlate_en` is high, or when `maint_en` is high and the reference is a write. Otherwise `rsp_paddr` equals the zero-extended virtual address and no fault is raised, whatever the descriptor, memory size or I/O base.
- R4: Access-control codes give these outcomes (read / write). 0, 3 and 7: abort / abort. 1: trap / abort. 2: proceed / abort. 4: trap / trap. 5: proceed / trap. 6: proceed / proceed. Abort is `rsp_vector` = 4 and trap is `rsp_vector` = 168 (250 octal); with no fault, `rsp_vector` = 0.
- R5: `rsp_kind` encodes 0 = none, 1 = non-resident, 2 = read-only, 3 = length. An access fault gives kind 1 for codes 0 and 4 and kind 2 for every other code.
- R6: A physical address at or above `mem_size` and below `io_base` aborts with kind 1. An address equal to `io_base` does not fault.
- R7: The length check compares `req_vaddr[12:6]` with `rf_len`. When `rf_down` is 0 it faults if the virtual value is greater. When `rf_down` is 1 it faults if the virtual value is smaller. A length fault traps with kind 3.
- R8: The checks are evaluated in the order access control, non-existent memory, length, and only the first failure is reported.
- R9: `rsp_attn` is 1 exactly when a write faults. `rsp_mode`, `rsp_space` and `rsp_page` give the mode, the space used and the page of the reference.
- R10: A data reference (`req_data` = 1) uses data-space registers (`rf_dspace` = 1, `rsp_space` = 1) only when `dspace_en` is high. Otherwise it uses instruction space (0). An instruction reference always uses space 0.
- R11: A response is registered one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged, `req_ready` is low, and an offered request is not accepted.
- R12: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 16 | Virtual address |
| req_mode | input | 2 | Processor mode of the reference |
| req_data | input | 1 | 1 = data reference, 0 = instruction |
| req_write | input | 1 | 1 = write |
| xlate_en | input | 1 | Translation enable |
| maint_en | input | 1 | Maintenance: translate writes only |
| ext22_en | input | 1 | Keep 22-bit physical addresses |
| dspace_en | input | 1 | Data space enabled for the current mode |
| mem_size | input | 22 | First non-existent physical address |
| io_base | input | 22 | First physical address of the I/O region |
| rf_page | output | 3 | Page select to register file |
| rf_dspace | output | 1 | Space select to register file |
| rf_base | input | 16 | Page base from register file |
| rf_acc | input | 3 | Access-control code |
| rf_len | input | 7 | Page length field |
| rf_down | input | 1 | 1 = page grows downward |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 22 | Physical address |
| rsp_fault | output | 1 | Reference failed |
| rsp_vector | output | 8 | 4 abort, 168 trap, 0 none |
| rsp_kind | output | 2 | Fault kind |
| rsp_attn | output | 1 | Written-page attention |
| rsp_mode | output | 2 | Mode of the reference |
| rsp_space | output | 1 | Space used |
| rsp_page | output | 3 | Page of the reference |

## Verification
On every cycle, the assertions check that a length fault always traps, and that a fault-free response carries no kind, no vector and no attention. They also check that any attention comes with a fault, that an address in the narrow mode has clear upper bits, and that a held response stays stable while back-pressured. The bench vectors are needed to show that each access code has the right read and write outcome. They also show the exact memory-size and I/O-base boundaries, the two length directions at their edge values, the check ordering when several checks fail together, the data-space fallback and the bypass when translation is off.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_NONRES = 2'd1,
    FK_RDONLY = 2'd2,
    FK_LEN    = 2'd3
  } fkind_e;

  localparam logic [7:0] VEC_NONE  = 8'd0;
  localparam logic [7:0] VEC_ABORT = 8'd4;
  localparam logic [7:0] VEC_TRAP  = 8'd168;

  // returns {fault, is_trap} for an access-control code
  function automatic logic [1:0] acc_eval(input logic [2:0] code, input logic wr);
    case (code)
      3'd1:    acc_eval = wr ? 2'b10 : 2'b11;
      3'd2:    acc_eval = wr ? 2'b10 : 2'b00;
      3'd4:    acc_eval = 2'b11;
      3'd5:    acc_eval = wr ? 2'b11 : 2'b00;
      3'd6:    acc_eval = 2'b00;
      default: acc_eval = 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/pxl_map.sv
module pxl_map #(
  parameter int VA_W      = 16,
  parameter int PG_W      = 3,
  parameter int BASE_W    = 16,
  parameter int BLK_SH    = 6,
  parameter int PA_W      = 22,
  parameter int PA_NARROW = 18
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic              is_data,
  input  logic              is_write,
  input  logic              xen,
  input  logic              mnt,
  input  logic              wide,
  input  logic              dsen,
  input  logic [BASE_W-1:0] base,
  output logic [PG_W-1:0]   page,
  output logic              dspace,
  output logic              translate,
  output logic [PA_W-1:0]   paddr
);
  localparam int OFF_W = VA_W - PG_W;
  localparam logic [PA_W-1:0] NARROW_MASK = {{(PA_W-PA_NARROW){1'b0}}, {PA_NARROW{1'b1}}};

  logic [PA_W-1:0] base_sh, sum, fitted;

  always_comb begin
    page      = vaddr[VA_W-1 -: PG_W];
    dspace    = is_data & dsen;
    translate = xen | (mnt & is_write);
    base_sh   = PA_W'({base, {BLK_SH{1'b0}}});
    sum       = base_sh + PA_W'(vaddr[OFF_W-1:0]);
    fitted    = wide ? sum : (sum & NARROW_MASK);
    paddr     = translate ? fitted : PA_W'(vaddr);
  end

  always_comb begin
    if (translate && !wide)
      assert_narrow_clear_R2: assert (paddr[PA_W-1:PA_NARROW] == '0);
  end
endmodule

// File: rtl/pxl_check.sv
module pxl_check
  import pxl_pkg::*;
#(
  parameter int PA_W  = 22,
  parameter int LEN_W = 7
) (
  input  logic             translate,
  input  logic             is_write,
  input  logic [2:0]       acc,
  input  logic [PA_W-1:0]  paddr,
  input  logic [PA_W-1:0]  mem_size,
  input  logic [PA_W-1:0]  io_base,
  input  logic [LEN_W-1:0] blk,
  input  logic [LEN_W-1:0] len,
  input  logic             down,
  output logic             fault,
  output logic [7:0]       vector,
  output fkind_e           kind,
  output logic             attn
);
  logic [1:0] acc_res;
  logic       nxm_hit, len_hit;

  always_comb begin
    acc_res = acc_eval(acc, is_write);
    nxm_hit = (paddr >= mem_size) && (paddr < io_base);
    len_hit = down ? (blk < len) : (blk > len);
    fault   = 1'b0;
    vector  = VEC_NONE;
    kind    = FK_NONE;
    if (translate) begin
      if (acc_res[1]) begin
        fault  = 1'b1;
        vector = acc_res[0] ? VEC_TRAP : VEC_ABORT;
        kind   = (acc == 3'd0 || acc == 3'd4) ? FK_NONRES : FK_RDONLY;
      end else if (nxm_hit) begin
        fault  = 1'b1;
        vector = VEC_ABORT;
        kind   = FK_NONRES;
      end else if (len_hit) begin
        fault  = 1'b1;
        vector = VEC_TRAP;
        kind   = FK_LEN;
      end
    end
    attn = fault & is_write;
  end

  always_comb begin
    if (translate && acc == 3'd6 && nxm_hit)
      assert_nxm_after_acc_R8: assert (kind == FK_NONRES && vector == VEC_ABORT);
    if (!translate)
      assert_bypass_clean_R3: assert (!fault);
  end
endmodule

// File: rtl/pxl_top.sv
module pxl_top
  import pxl_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PG_W      = 3,
  parameter int BASE_W    = 16,
  parameter int BLK_SH    = 6,
  parameter int PA_W      = 22,
  parameter int PA_NARROW = 18,
  parameter int ACC_W     = 3,
  parameter int MODE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic                 req_data,
  input  logic                 req_write,
  input  logic                 xlate_en,
  input  logic                 maint_en,
  input  logic                 ext22_en,
  input  logic                 dspace_en,
  input  logic [PA_W-1:0]      mem_size,
  input  logic [PA_W-1:0]      io_base,
  output logic [PG_W-1:0]      rf_page,
  output logic                 rf_dspace,
  input  logic [BASE_W-1:0]    rf_base,
  input  logic [ACC_W-1:0]     rf_acc,
  input  logic [VA_W-PG_W-BLK_SH-1:0] rf_len,
  input  logic                 rf_down,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_fault,
  output logic [7:0]           rsp_vector,
  output logic [1:0]           rsp_kind,
  output logic                 rsp_attn,
  output logic [MODE_W-1:0]    rsp_mode,
  output logic                 rsp_space,
  output logic [PG_W-1:0]      rsp_page
);
  localparam int OFF_W = VA_W - PG_W;
  localparam int LEN_W = OFF_W - BLK_SH;

  logic            translate, c_fault, c_attn;
  logic [PA_W-1:0] c_paddr;
  logic [7:0]      c_vec;
  fkind_e          c_kind;
  logic            accept;

  pxl_map #(
    .VA_W(VA_W), .PG_W(PG_W), .BASE_W(BASE_W), .BLK_SH(BLK_SH),
    .PA_W(PA_W), .PA_NARROW(PA_NARROW)
  ) u_map (
    .vaddr(req_vaddr), .is_data(req_data), .is_write(req_write),
    .xen(xlate_en), .mnt(maint_en), .wide(ext22_en), .dsen(dspace_en),
    .base(rf_base), .page(rf_page), .dspace(rf_dspace),
    .translate(translate), .paddr(c_paddr)
  );

  pxl_check #(.PA_W(PA_W), .LEN_W(LEN_W)) u_chk (
    .translate(translate), .is_write(req_write), .acc(rf_acc),
    .paddr(c_paddr), .mem_size(mem_size), .io_base(io_base),
    .blk(req_vaddr[OFF_W-1:BLK_SH]), .len(rf_len), .down(rf_down),
    .fault(c_fault), .vector(c_vec), .kind(c_kind), .attn(c_attn)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= 1'b0;
      rsp_vector <= '0;
      rsp_kind   <= '0;
      rsp_attn   <= 1'b0;
      rsp_mode   <= '0;
      rsp_space  <= 1'b0;
      rsp_page   <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_paddr  <= c_paddr;
      rsp_fault  <= c_fault;
      rsp_vector <= c_vec;
      rsp_kind   <= c_kind;
      rsp_attn   <= c_attn;
      rsp_mode   <= req_mode;
      rsp_space  <= rf_dspace;
      rsp_page   <= rf_page;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assert_len_traps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == FK_LEN) |-> (rsp_vector == VEC_TRAP));
  assert_clean_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_kind == FK_NONE && rsp_vector == VEC_NONE && !rsp_attn));
  assert_attn_has_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_attn) |-> (rsp_fault && rsp_kind != FK_NONE));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                   && $stable(rsp_vector) && $stable(rsp_kind)));
endmodule

// File: tb/tb_pxl_top.sv
module tb_pxl_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_ready, req_data = 0, req_write = 0;
  logic [15:0] req_vaddr = 0;
  logic [1:0]  req_mode = 0;
  logic        xlate_en = 0, maint_en = 0, ext22_en = 0, dspace_en = 0;
  logic [21:0] mem_size = 0, io_base = 0;
  logic [2:0]  rf_page;
  logic        rf_dspace;
  logic [15:0] rf_base = 0;
  logic [2:0]  rf_acc = 0;
  logic [6:0]  rf_len = 0;
  logic        rf_down = 0;
  logic        rsp_valid, rsp_ready = 1, rsp_fault, rsp_attn, rsp_space;
  logic [21:0] rsp_paddr;
  logic [7:0]  rsp_vector;
  logic [1:0]  rsp_kind, rsp_mode;
  logic [2:0]  rsp_page;

  pxl_top dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0]  rq;
    logic [15:0] va;
    logic [1:0]  md;
    logic dt, wr, xe, mn, e22, ds;
    logic [15:0] bs;
    logic [2:0]  ac;
    logic [6:0]  ln;
    logic        dn;
    logic [21:0] ms, io, pa;
    logic        fl;
    logic [7:0]  vc;
    logic [1:0]  kd;
    logic        at, sp;
  } vec_t;

  localparam logic [21:0] M = 22'h020000;
  localparam logic [21:0] I = 22'h3FE000;
  localparam int N = 36;
  localparam vec_t TV [0:N-1] = '{
    // R3 bypass, R1 mapping under maintenance
    '{4'd3, 16'hA123, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd0, 7'h7F, 1'b0, M, I, 22'h00A123, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd3, 16'h2010, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 3'd6, 7'h7F, 1'b0, M, I, 22'h004010, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd3, 16'h2010, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 3'd0, 7'h7F, 1'b0, M, I, 22'h002010, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd3, 16'h1234, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 3'd0, 7'h00, 1'b0, 22'h0, I, 22'h001234, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    // R4 access codes, read then write
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd0, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd1, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd0, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd1, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd1, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd168, 2'd2, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd1, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd2, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd2, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd2, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd2, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd3, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd2, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd3, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd2, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd4, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd168, 2'd1, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd4, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd168, 2'd1, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd5, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd5, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd168, 2'd2, 1'b1, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd7, 7'h7F, 1'b0, M, I, 22'h0, 1'b1, 8'd4,   2'd2, 1'b0, 1'b0},
    // R2 wide and narrow, R1 page offset
    '{4'd2, 16'h1FFF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8000, 3'd6, 7'h7F, 1'b0, 22'h3F0000, I, 22'h201FFF, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    '{4'd2, 16'h1FFF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 3'd6, 7'h7F, 1'b0, M, I, 22'h001FFF, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    '{4'd1, 16'hA0C0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0010, 3'd6, 7'h7F, 1'b0, M, I, 22'h0004C0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    // R6 memory size and I/O boundaries
    '{4'd6, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0400, 3'd6, 7'h7F, 1'b0, 22'h010000, I, 22'h010000, 1'b1, 8'd4, 2'd1, 1'b0, 1'b0},
    '{4'd6, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h03FF, 3'd6, 7'h7F, 1'b0, 22'h010000, I, 22'h00FFC0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    '{4'd6, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFF80, 3'd6, 7'h7F, 1'b0, M, I, 22'h3FE000, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    '{4'd6, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFF7F, 3'd6, 7'h7F, 1'b0, M, I, 22'h3FDFC0, 1'b1, 8'd4, 2'd1, 1'b1, 1'b0},
    // R7 length, upward and downward edges
    '{4'd7, 16'h0140, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'd5, 1'b0, M, I, 22'h000140, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd7, 16'h0180, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'd5, 1'b0, M, I, 22'h000180, 1'b1, 8'd168, 2'd3, 1'b0, 1'b0},
    '{4'd7, 16'h0140, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'd5, 1'b1, M, I, 22'h000140, 1'b0, 8'd0,   2'd0, 1'b0, 1'b0},
    '{4'd7, 16'h0100, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'd5, 1'b1, M, I, 22'h000100, 1'b1, 8'd168, 2'd3, 1'b0, 1'b0},
    '{4'd9, 16'h0100, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'd5, 1'b1, M, I, 22'h000100, 1'b1, 8'd168, 2'd3, 1'b1, 1'b0},
    // R8 ordering with several failing checks
    '{4'd8, 16'h0180, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0400, 3'd1, 7'd5, 1'b0, 22'h010000, I, 22'h010180, 1'b1, 8'd168, 2'd2, 1'b0, 1'b0},
    '{4'd8, 16'h0180, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0400, 3'd6, 7'd5, 1'b0, 22'h010000, I, 22'h010180, 1'b1, 8'd4,   2'd1, 1'b0, 1'b0},
    '{4'd8, 16'h0180, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0400, 3'd5, 7'd5, 1'b0, 22'h010000, I, 22'h010180, 1'b1, 8'd4,   2'd1, 1'b0, 1'b0},
    // R10 data-space selection
    '{4'd10, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd6, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0},
    '{4'd10, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 3'd6, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b1},
    '{4'd10, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 3'd6, 7'h7F, 1'b0, M, I, 22'h0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_vaddr = v.va; req_mode = v.md; req_data = v.dt; req_write = v.wr;
    xlate_en = v.xe; maint_en = v.mn; ext22_en = v.e22; dspace_en = v.ds;
    rf_base = v.bs; rf_acc = v.ac; rf_len = v.ln; rf_down = v.dn;
    mem_size = v.ms; io_base = v.io;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string t;
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = $sformatf("R%0d row %0d", v.rq, idx);
    chk({t, " valid"}, 32'(rsp_valid), 32'd1);
    chk({t, " paddr"}, 32'(rsp_paddr), 32'(v.pa));
    chk({t, " fault"}, 32'(rsp_fault), 32'(v.fl));
    chk({t, " vector"}, 32'(rsp_vector), 32'(v.vc));
    chk($sformatf("R5 row %0d kind", idx), 32'(rsp_kind), 32'(v.kd));
    chk($sformatf("R9 row %0d attn", idx), 32'(rsp_attn), 32'(v.at));
    chk($sformatf("R9 row %0d mode", idx), 32'(rsp_mode), 32'(v.md));
    chk($sformatf("R10 row %0d space", idx), 32'(rsp_space), 32'(v.sp));
    chk($sformatf("R10 row %0d rf_dspace", idx), 32'(rf_dspace), 32'(v.sp));
    chk($sformatf("R1 row %0d page", idx), 32'(rsp_page), 32'(v.va[15:13]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R12 req_ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < N; i++) run_vec(TV[i], i);

    // R11 back-pressure: held response, second request refused
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(TV[4]);
    req_valid = 1'b1;
    @(negedge clk);
    drive(TV[21]);
    @(negedge clk);
    chk("R11 held valid", 32'(rsp_valid), 32'd1);
    chk("R11 ready low while held", 32'(req_ready), 32'd0);
    chk("R11 held paddr", 32'(rsp_paddr), 32'h0);
    chk("R11 held fault", 32'(rsp_fault), 32'd1);
    chk("R11 held vector", 32'(rsp_vector), 32'd4);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 refused request gave no response", 32'(rsp_valid), 32'd0);

    // R12 reset while a response is pending
    rsp_ready = 1'b0;
    drive(TV[1]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset clears pending response", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 ready after second reset", 32'(req_ready), 32'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule